// File: doc/BRIEF.md
# Dispatch Slot Controller

This block sits between a decoded instruction stream and an out-of-order back end. It decides, in the same cycle that requests are presented, which of up to `LANES` head instructions are dispatched. Lanes are taken in program order. The decision depends on the number of micro-op slots left in the cycle, the group-boundary flags, the free space in the reorder buffer, register-file readiness and the readiness of the next stage. The block holds no instructions. A lane that is not accepted must be presented again in a later cycle.

An instruction with more micro-ops than the dispatch width `W` fills every slot in its first cycle. The remainder is held as a carry-over count and drains over the following cycles. New instructions can use only the slots that the drain leaves free. Every cycle the block reports how many slots it used. When the lane at the head of the refused lanes fits the slots but lacks reorder-buffer room or register-file resources, the block raises a stall pulse that names the cause.

Top module: `dispatch_slot_ctrl`

## Requirements
- R1: After a synchronous active-high reset, no carry-over is pending and all `W` slots are available in the first cycle.
- R2: Lanes are examined from lane 0 upward. An invalid or refused lane stops every higher lane, so accepted lanes always form a contiguous run that starts at lane 0, and only valid lanes are accepted.
- R3: A lane needs min(uop count, `W`) slots. It is refused when no slot remains or when it needs more slots than remain.
- R4: A lane flagged begin-group is accepted only when all `W` slots are still free in that cycle: no earlier lane was accepted and no carry-over is draining.
- R5: After a lane flagged end-group is accepted, no further lane is accepted in that cycle.
- R6: An accepted lane with uop count greater than `W` uses all `W` slots and leaves count−`W` as carry-over. In each following cycle the drain uses min(carry, `W`) slots and new lanes may use only the slots left over. Example: 7 uops at `W`=4 uses 4 slots, then 3 slots plus 1 free slot.
- R7: The reorder buffer must hold the lane's full uop count. The input `robFree` is reduced by the uop counts of lanes accepted earlier in the same cycle.
- R8: A lane is accepted only when its `rfReady` bit is 1 and `nextReady` is 1.
- R9: For the first valid lane that is refused, and only when it passes the slot and begin-group checks, `stallRob` is 1 if reorder-buffer room is short and `stallRf` is 1 if its `rfReady` is 0. Otherwise both are 0.
- R10: `slotsUsed` equals the carry-over drain of the cycle plus the sum of min(uop count, `W`) over accepted lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | LANES | Lane holds an instruction |
| reqUops | input | LANES x UOP_W | Micro-op count per lane (1 or more) |
| reqBegin | input | LANES | Lane must open a dispatch group |
| reqEnd | input | LANES | Lane closes the dispatch group |
| rfReady | input | LANES | Register-file resources free for the lane |
| robFree | input | ROB_W | Free reorder-buffer entries this cycle |
| nextReady | input | 1 | Next stage can take instructions this cycle |
| accept | output | LANES | Lane dispatched this cycle |
| stallRob | output | 1 | Head refusal caused by reorder-buffer room |
| stallRf | output | 1 | Head refusal caused by register-file resources |
| slotsUsed | output | SLOT_W | Slots consumed this cycle (drain plus new) |

## Verification
The bench builds the block with `W`=4, four lanes, a 4-bit uop count and a 6-bit reorder-buffer count. With a 4-bit count, a single instruction can carry up to 11 extra micro-ops, so one instruction can fill the carry-over for three cycles in a row. With four lanes, a whole cycle can run out of slots from 1-uop instructions alone. The 6-bit free count, kept below 20 in random traffic, makes reorder-buffer shortfalls in the middle of a cycle frequent. Begin-group and end-group flags then meet both a partly used cycle and a cycle with carry-over draining.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  // Strobes from the lane evaluation logic to the carry datapath.
  typedef struct packed {
    logic wideTaken;   // lane 0 accepted with more uops than the width
  } dscStrobes_t;
endpackage

// File: rtl/dsc_carry_path.sv
module dsc_carry_path
  import dsc_pkg::*;
#(
  parameter int W      = 4,
  parameter int UOP_W  = 4,
  parameter int SLOT_W = $clog2(W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  dscStrobes_t       strobes,
  input  logic [UOP_W-1:0]  lane0Uops,
  input  logic [SLOT_W-1:0] newSlots,
  output logic [SLOT_W-1:0] availStart,
  output logic [SLOT_W-1:0] slotsUsed
);
  logic [UOP_W-1:0] carryQ;
  logic [UOP_W-1:0] carryD;

  // Start-of-cycle view: drain the pending excess first.
  always_comb begin
    int carry;
    int drain;
    int avail;
    carry = int'(carryQ);
    if (carry == 0) begin
      drain = 0;
      avail = W;
    end else if (carry >= W) begin
      drain = W;
      avail = 0;
    end else begin
      drain = carry;
      avail = W - carry;
    end
    availStart = SLOT_W'(avail);
    slotsUsed  = SLOT_W'(drain + int'(newSlots));
    if (strobes.wideTaken) carryD = UOP_W'(int'(lane0Uops) - W);
    else                   carryD = UOP_W'(carry - drain);
  end

  always_ff @(posedge clk) begin
    if (rst) carryQ <= '0;
    else     carryQ <= carryD;
  end
endmodule

// File: rtl/dsc_slot_ctrl.sv
module dsc_slot_ctrl
  import dsc_pkg::*;
#(
  parameter int W      = 4,
  parameter int LANES  = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6,
  parameter int SLOT_W = $clog2(W + 1)
) (
  input  logic [SLOT_W-1:0]           availStart,
  input  logic [LANES-1:0]            reqValid,
  input  logic [LANES-1:0][UOP_W-1:0] reqUops,
  input  logic [LANES-1:0]            reqBegin,
  input  logic [LANES-1:0]            reqEnd,
  input  logic [LANES-1:0]            rfReady,
  input  logic [ROB_W-1:0]            robFree,
  input  logic                        nextReady,
  output logic [LANES-1:0]            accept,
  output logic                        stallRob,
  output logic                        stallRf,
  output logic [SLOT_W-1:0]           newSlots,
  output dscStrobes_t                 strobes
);
  always_comb begin
    int   avail;
    int   robLeft;
    int   used;
    int   need;
    int   uops;
    logic chainOpen;
    logic fits;
    avail     = int'(availStart);
    robLeft   = int'(robFree);
    used      = 0;
    chainOpen = 1'b1;
    accept    = '0;
    stallRob  = 1'b0;
    stallRf   = 1'b0;
    strobes   = '0;
    for (int i = 0; i < LANES; i++) begin
      uops = int'(reqUops[i]);
      need = (uops > W) ? W : uops;
      fits = (avail != 0) && (need <= avail) && (!reqBegin[i] || avail == W);
      if (chainOpen) begin
        if (!reqValid[i]) begin
          chainOpen = 1'b0;
        end else if (fits && robLeft >= uops && rfReady[i] && nextReady) begin
          accept[i] = 1'b1;
          used      = used + need;
          robLeft   = robLeft - uops;
          if (uops > W) strobes.wideTaken = 1'b1;
          avail = (reqEnd[i] || uops > W) ? 0 : avail - need;
        end else begin
          chainOpen = 1'b0;
          if (fits) begin
            stallRob = (robLeft < uops);
            stallRf  = !rfReady[i];
          end
        end
      end
    end
    newSlots = SLOT_W'(used);
  end
endmodule

// File: rtl/dispatch_slot_ctrl.sv
module dispatch_slot_ctrl
  import dsc_pkg::*;
#(
  parameter int W      = 4,
  parameter int LANES  = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6,
  localparam int SLOT_W = $clog2(W + 1)
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [LANES-1:0]            reqValid,
  input  logic [LANES-1:0][UOP_W-1:0] reqUops,
  input  logic [LANES-1:0]            reqBegin,
  input  logic [LANES-1:0]            reqEnd,
  input  logic [LANES-1:0]            rfReady,
  input  logic [ROB_W-1:0]            robFree,
  input  logic                        nextReady,
  output logic [LANES-1:0]            accept,
  output logic                        stallRob,
  output logic                        stallRf,
  output logic [SLOT_W-1:0]           slotsUsed
);
  dscStrobes_t       strobes;
  logic [SLOT_W-1:0] availStart;
  logic [SLOT_W-1:0] newSlots;

  dsc_slot_ctrl #(.W(W), .LANES(LANES), .UOP_W(UOP_W), .ROB_W(ROB_W), .SLOT_W(SLOT_W)) ctrl (
    .availStart(availStart), .reqValid(reqValid), .reqUops(reqUops),
    .reqBegin(reqBegin), .reqEnd(reqEnd), .rfReady(rfReady),
    .robFree(robFree), .nextReady(nextReady), .accept(accept),
    .stallRob(stallRob), .stallRf(stallRf), .newSlots(newSlots),
    .strobes(strobes)
  );

  dsc_carry_path #(.W(W), .UOP_W(UOP_W), .SLOT_W(SLOT_W)) path (
    .clk(clk), .rst(rst), .strobes(strobes), .lane0Uops(reqUops[0]),
    .newSlots(newSlots), .availStart(availStart), .slotsUsed(slotsUsed)
  );
endmodule

// File: rtl/dispatch_slot_ctrl_checker.sv
module dispatch_slot_ctrl_checker #(
  parameter int W      = 4,
  parameter int LANES  = 4,
  parameter int UOP_W  = 4,
  parameter int ROB_W  = 6,
  parameter int SLOT_W = $clog2(W + 1)
) (
  input logic                        clk,
  input logic                        rst,
  input logic [LANES-1:0]            reqValid,
  input logic [LANES-1:0][UOP_W-1:0] reqUops,
  input logic [LANES-1:0]            reqBegin,
  input logic [LANES-1:0]            reqEnd,
  input logic [LANES-1:0]            rfReady,
  input logic [ROB_W-1:0]            robFree,
  input logic                        nextReady,
  input logic [LANES-1:0]            accept,
  input logic                        stallRob,
  input logic                        stallRf,
  input logic [SLOT_W-1:0]           slotsUsed
);
  int robTaken;
  always_comb begin
    robTaken = 0;
    for (int i = 0; i < LANES; i++)
      if (accept[i]) robTaken = robTaken + int'(reqUops[i]);
  end

  AST_ACCEPT_RUN: assert property (@(posedge clk) disable iff (rst)
    ((accept & (accept + 1'b1)) == '0)); // R2
  AST_ACCEPT_VALID: assert property (@(posedge clk) disable iff (rst)
    ((accept & ~reqValid) == '0)); // R2
  AST_SLOTS_BOUND: assert property (@(posedge clk) disable iff (rst)
    (int'(slotsUsed) <= W)); // R10
  AST_WIDE_FULL: assert property (@(posedge clk) disable iff (rst)
    (accept[0] && int'(reqUops[0]) > W) |-> (int'(slotsUsed) == W)); // R6
  AST_WIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (accept[0] && int'(reqUops[0]) > 2 * W) |=> (accept == '0 && int'(slotsUsed) == W)); // R6
  AST_ROB_COVERED: assert property (@(posedge clk) disable iff (rst)
    (robTaken <= int'(robFree))); // R7
  AST_NEXT_GATE: assert property (@(posedge clk) disable iff (rst)
    (!nextReady |-> accept == '0)); // R8
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    ((stallRob || stallRf) |-> ((reqValid & ~accept) != '0))); // R9

  for (genvar g = 1; g < LANES; g++) begin : gLane
    AST_BEGIN_FIRST: assert property (@(posedge clk) disable iff (rst)
      !(accept[g] && reqBegin[g])); // R4
    AST_END_CLOSES: assert property (@(posedge clk) disable iff (rst)
      (accept[g-1] && reqEnd[g-1]) |-> !accept[g]); // R5
    AST_RF_GATE: assert property (@(posedge clk) disable iff (rst)
      (accept[g] |-> rfReady[g])); // R8
  end
endmodule

bind dispatch_slot_ctrl dispatch_slot_ctrl_checker #(
  .W(W), .LANES(LANES), .UOP_W(UOP_W), .ROB_W(ROB_W), .SLOT_W(SLOT_W)
) chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqUops(reqUops),
  .reqBegin(reqBegin), .reqEnd(reqEnd), .rfReady(rfReady),
  .robFree(robFree), .nextReady(nextReady), .accept(accept),
  .stallRob(stallRob), .stallRf(stallRf), .slotsUsed(slotsUsed)
);

// File: tb/dispatch_slot_ctrl_test.sv
module dispatch_slot_ctrl_test;
  localparam int W      = 4;
  localparam int LANES  = 4;
  localparam int UOP_W  = 4;
  localparam int ROB_W  = 6;
  localparam int SLOT_W = $clog2(W + 1);

  logic                        clk = 1'b0;
  logic                        rst;
  logic [LANES-1:0]            reqValid;
  logic [LANES-1:0][UOP_W-1:0] reqUops;
  logic [LANES-1:0]            reqBegin;
  logic [LANES-1:0]            reqEnd;
  logic [LANES-1:0]            rfReady;
  logic [ROB_W-1:0]            robFree;
  logic                        nextReady;
  logic [LANES-1:0]            accept;
  logic                        stallRob;
  logic                        stallRf;
  logic [SLOT_W-1:0]           slotsUsed;

  int checks = 0;
  int fails  = 0;
  int pendingExcess = 0;   // model: uops still owed by a wide instruction
  logic done = 1'b0;

  always #2 clk = ~clk;    // 250 MHz

  dispatch_slot_ctrl #(.W(W), .LANES(LANES), .UOP_W(UOP_W), .ROB_W(ROB_W)) uut (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqUops(reqUops),
    .reqBegin(reqBegin), .reqEnd(reqEnd), .rfReady(rfReady),
    .robFree(robFree), .nextReady(nextReady), .accept(accept),
    .stallRob(stallRob), .stallRf(stallRf), .slotsUsed(slotsUsed)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    reqValid = '0; reqUops = '0; reqBegin = '0; reqEnd = '0;
    rfReady = '1; robFree = ROB_W'(40); nextReady = 1'b1;
  endtask

  task automatic lane(int i, int uops, bit b = 0, bit e = 0, bit rf = 1);
    reqValid[i] = 1'b1;
    reqUops[i]  = UOP_W'(uops);
    reqBegin[i] = b;
    reqEnd[i]   = e;
    rfReady[i]  = rf;
  endtask

  // Called just after a falling edge with inputs set; checks, then advances.
  task automatic step(string tag);
    int free, drain, robLeft, used, owed, u, need;
    bit open, fits;
    logic [LANES-1:0] expAcc;
    bit expRob, expRf;
    #1;
    if (pendingExcess == 0) begin free = W; drain = 0; end
    else if (pendingExcess >= W) begin free = 0; drain = W; end
    else begin free = W - pendingExcess; drain = pendingExcess; end
    owed = pendingExcess - drain;
    used = drain; robLeft = int'(robFree); open = 1; expAcc = '0; expRob = 0; expRf = 0;
    for (int i = 0; i < LANES; i++) begin
      if (!open) continue;
      if (!reqValid[i]) begin open = 0; continue; end
      u = int'(reqUops[i]);
      need = (u < W) ? u : W;
      fits = free > 0 && need <= free && (!reqBegin[i] || free == W);
      if (fits && robLeft >= u && rfReady[i] && nextReady) begin
        expAcc[i] = 1'b1;
        used += need;
        robLeft -= u;
        if (u > W) begin owed = u - W; free = 0; end
        else free -= need;
        if (reqEnd[i]) free = 0;
      end else begin
        open = 0;
        if (fits) begin expRob = robLeft < u; expRf = !rfReady[i]; end
      end
    end
    if (!rst) begin
      check(tag, "accept", int'(accept), int'(expAcc));
      check(tag, "stallRob", int'(stallRob), int'(expRob));
      check(tag, "stallRf", int'(stallRf), int'(expRf));
      check(tag, "slotsUsed", int'(slotsUsed), used);
    end
    @(posedge clk);
    pendingExcess = rst ? 0 : owed;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; idle();
    @(negedge clk); step("R1 reset"); step("R1 reset");
    rst = 1'b0;
    // R1: full width available right after reset
    idle(); for (int i = 0; i < LANES; i++) lane(i, 1);
    step("R1");
    // R6: 7 uops at width 4 spans two cycles; 3 slots drained in the second
    idle(); lane(0, 7); lane(1, 1); step("R6 wide start");
    idle(); lane(0, 1); lane(1, 1); step("R6 drain 3");
    // R6: 15 uops, three drain cycles
    idle(); lane(0, 15); step("R6 wide15");
    idle(); lane(0, 1); step("R6 hold1");
    idle(); lane(0, 1); step("R6 hold2");
    idle(); lane(0, 1, 1); step("R4 begin blocked by drain");
    idle(); lane(0, 1, 1); lane(1, 1); step("R4 begin lane0");
    // R4: begin in lane 1 after lane 0
    idle(); lane(0, 1); lane(1, 1, 1); lane(2, 1); step("R4 begin lane1");
    // R5: end-group closes cycle
    idle(); lane(0, 2, 0, 1); lane(1, 1); step("R5");
    // R3: slot shortfall, no stall
    idle(); lane(0, 3); lane(1, 2); step("R3 shortfall");
    idle(); lane(0, 4); lane(1, 1); step("R3 zero left");
    // R7 / R9: reorder buffer short for lane 1
    idle(); robFree = ROB_W'(3); lane(0, 2); lane(1, 2); step("R7 R9 rob");
    // R8 / R9: register file not ready
    idle(); lane(0, 1, 0, 0, 0); step("R8 R9 rf");
    idle(); robFree = ROB_W'(0); lane(0, 1, 0, 0, 0); step("R9 both");
    // R8: next stage not ready
    idle(); nextReady = 1'b0; lane(0, 1); lane(1, 1); step("R8 next");
    // R2: gap stops later lanes
    idle(); lane(0, 1); lane(2, 1); step("R2 gap");
    // R10 plus everything: random traffic
    for (int n = 0; n < 400; n++) begin
      idle();
      robFree   = ROB_W'($urandom % 20);
      nextReady = ($urandom % 8) != 0;
      for (int i = 0; i < LANES; i++)
        if (($urandom % 6) != 0)
          lane(i, 1 + ($urandom % 10), ($urandom % 8) == 0,
               ($urandom % 8) == 0, ($urandom % 6) != 0);
      step("R10 random");
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule